// File: doc/BRIEF.md
# Converter Output Formatter with Scrambler

This block takes each 14-bit result of a sampling converter core, together with its range-error indication, and turns it into the word that leaves the chip. A 2-bit mode code selects offset binary or two's complement. The same code also sets a clock duty-cycle stabilizer enable, which is brought out as a status pin. When scrambling is enabled, every data bit above the least significant one is XORed with that bit. This spreads digital switching activity away from the signal.

The formatted word, the overflow flag and a pair of complementary output clocks all come from one output register. The path in is a valid/ready stream. A sample is accepted on a rising edge where both `in_valid` and `in_ready` are high, and it appears one cycle later with `out_valid` high. `in_ready` is high when the output register is empty or is being read in the same cycle (`out_ready` high). A presented word stays unchanged until `out_ready` takes it. A separate receive-side path restores the formatted word from a scrambled one.

Top module: `adc_out_fmt`

## Requirements
- R1: After reset, `out_valid`=0, `out_data`=0, `out_ovf`=0, `out_clk_p`=0 and `out_clk_n`=1.
- R2: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold their values.
- R3: A sample accepted on one edge is presented with `out_valid`=1 after that same edge, a latency of one cycle.
- R4: Modes 0 and 1 output the code in offset binary, which is the raw code unchanged.
- R5: Modes 2 and 3 output two's complement, formed by inverting bit 13 only.
- R6: `dcs_en` is 1 for modes 1 and 2 and 0 for modes 0 and 3.
- R7: With `rand_en`=1 at acceptance, output bits 13..1 are the formatted bits XORed with formatted bit 0, and bit 0 is sent unchanged. Formatting happens before this XOR.
- R8: With `rand_en`=0 at acceptance, the formatted word is sent with no XOR.
- R9: `out_ovf` carries the `in_ovr` value of the accepted sample.
- R10: `out_clk_p` toggles on each accepted sample, so its first presented sample shows 1. `out_clk_n` is always its complement.
- R11: `rx_word` equals `rx_data` with bits 13..1 XORed with `rx_data[0]` when `rx_derand_en`=1, and equals `rx_data` otherwise. Fed with `out_data`, it returns the formatted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encode clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_code | input | 14 | Raw offset-binary conversion result |
| in_ovr | input | 1 | Sample over- or under-range |
| mode | input | 2 | Format and stabilizer selection |
| rand_en | input | 1 | Scrambling enable |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 14 | Formatted, optionally scrambled word |
| out_ovf | output | 1 | Overflow flag of the presented word |
| out_clk_p | output | 1 | Output clock, true form |
| out_clk_n | output | 1 | Output clock, complement form |
| dcs_en | output | 1 | Duty-cycle stabilizer enable status |
| rx_data | input | 14 | Received word for descrambling |
| rx_derand_en | input | 1 | Descrambling enable |
| rx_word | output | 14 | Descrambled word |

## Verification
Assertions check several behaviours on every edge: stability under back-pressure, the one-cycle appearance of accepted samples, overflow transfer, inversion of the top bit in two's complement modes, that bit 0 passes the scrambler unchanged, and the output clocks' toggling and complementarity. Other behaviours need the bench's scenarios. These are the exact value of every scrambled bit across mixed modes, and the stabilizer status of each mode code. The bench also shows that descrambling a stream, with scrambling turned on and off between words, returns the formatted words while random stalls are applied.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;
  localparam int unsigned CODE_W = 14;

  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } fmt_e;

  typedef struct packed {
    fmt_e fmt;
    logic dcs_en;
  } mode_cfg_t;
endpackage

// File: rtl/adc_fmt_mode_dec.sv
module adc_fmt_mode_dec
  import adc_fmt_pkg::*;
(
  input  logic [1:0] mode,
  output mode_cfg_t  cfg
);
  always_comb begin
    unique case (mode)
      2'd0:    cfg = '{fmt: FMT_OFFSET, dcs_en: 1'b0};
      2'd1:    cfg = '{fmt: FMT_OFFSET, dcs_en: 1'b1};
      2'd2:    cfg = '{fmt: FMT_TWOS,   dcs_en: 1'b1};
      default: cfg = '{fmt: FMT_TWOS,   dcs_en: 1'b0};
    endcase
  end
endmodule

// File: rtl/adc_fmt_convert.sv
module adc_fmt_convert
  import adc_fmt_pkg::*;
#(
  parameter int unsigned W = 14
) (
  input  fmt_e         fmt,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned MSB = W - 1;

  always_comb begin
    dout      = din;
    dout[MSB] = din[MSB] ^ (fmt == FMT_TWOS);
  end
endmodule

// File: rtl/adc_fmt_xor.sv
module adc_fmt_xor #(
  parameter int unsigned W = 14
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic key;
  assign key     = en & din[0];
  assign dout[0] = din[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ key;
  end
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
  import adc_fmt_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_code,
  input  logic         in_ovr,
  input  logic [1:0]   mode,
  input  logic         rand_en,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_ovf,
  output logic         out_clk_p,
  output logic         out_clk_n,
  output logic         dcs_en,
  input  logic [W-1:0] rx_data,
  input  logic         rx_derand_en,
  output logic [W-1:0] rx_word
);
  localparam int unsigned MSB = W - 1;

  mode_cfg_t    cfg;
  logic [W-1:0] fmt_word;
  logic [W-1:0] tx_word;
  logic         load;

  adc_fmt_mode_dec u_dec (.mode(mode), .cfg(cfg));

  adc_fmt_convert #(.W(W)) u_conv (
    .fmt (cfg.fmt),
    .din (in_code),
    .dout(fmt_word)
  );

  adc_fmt_xor #(.W(W)) u_tx_xor (
    .en  (rand_en),
    .din (fmt_word),
    .dout(tx_word)
  );

  adc_fmt_xor #(.W(W)) u_rx_xor (
    .en  (rx_derand_en),
    .din (rx_data),
    .dout(rx_word)
  );

  assign dcs_en   = cfg.dcs_en;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
      out_clk_p <= 1'b0;
      out_clk_n <= 1'b1;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= tx_word;
      out_ovf   <= in_ovr;
      out_clk_p <= !out_clk_p;
      out_clk_n <= !out_clk_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a stalled word holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R3: one-cycle latency
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: overflow transfer
  a_r9_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_ovf == $past(in_ovr));

  // R5: two's complement inverts the top bit (scrambling off)
  a_r5_twos_msb: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && mode[1] && !rand_en |=> out_data[MSB] == !$past(in_code[MSB]));

  // R7: bit 0 leaves the scrambler untouched
  a_r7_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_data[0] == $past(in_code[0]));

  // R10: clock pair toggles per sample and stays complementary
  a_r10_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_clk_p != $past(out_clk_p));
  a_r10_compl: assert property (@(posedge clk) disable iff (!rst_n)
    out_clk_n == !out_clk_p);
endmodule

// File: tb/adc_out_fmt_bench.sv
module adc_out_fmt_bench;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [W-1:0] in_code = '0;
  logic in_ovr = 1'b0;
  logic [1:0] mode = 2'd0;
  logic rand_en = 1'b0;
  logic out_valid, out_ready = 1'b1;
  logic [W-1:0] out_data;
  logic out_ovf, out_clk_p, out_clk_n, dcs_en;
  logic [W-1:0] rx_data = '0;
  logic rx_derand_en = 1'b0;
  logic [W-1:0] rx_word;

  always #2 clk = ~clk;

  adc_out_fmt u_adc_out_fmt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_ovr(in_ovr), .mode(mode), .rand_en(rand_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ovf(out_ovf), .out_clk_p(out_clk_p), .out_clk_n(out_clk_n),
    .dcs_en(dcs_en), .rx_data(rx_data), .rx_derand_en(rx_derand_en),
    .rx_word(rx_word)
  );

  typedef struct {
    logic [W-1:0] data;
    logic [W-1:0] plain;
    logic         ovf;
    logic         rnd;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0, popped = 0;
  logic bp = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic held = 1'b0;
  logic [W-1:0] held_data = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // back-pressure generator
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp ? lfsr[0] : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R10 clk_n complement", {31'd0, out_clk_n}, {31'd0, !out_clk_p});
      if (held) begin
        check("R2 hold valid", {31'd0, out_valid}, 32'd1);
        check("R2 hold data", {18'd0, out_data}, {18'd0, held_data});
      end
      held = out_valid && !out_ready;
      held_data = out_data;
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check("R3 unexpected output", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = q.pop_front();
          popped++;
          check("R4/R5/R7/R8 data", {18'd0, out_data}, {18'd0, it.data});
          check("R9 overflow", {31'd0, out_ovf}, {31'd0, it.ovf});
          check("R10 clk_p phase", {31'd0, out_clk_p}, {31'd0, popped[0]});
          rx_data = out_data;
          rx_derand_en = it.rnd;
          #1;
          check("R11 derandomize", {18'd0, rx_word}, {18'd0, it.plain});
        end
      end
    end
  end

  task automatic send(input logic [W-1:0] c, input logic ov, input logic [1:0] m, input logic r);
    item_t it;
    logic [W-1:0] f;
    f = m[1] ? {~c[W-1], c[W-2:0]} : c;
    it.plain = f;
    it.data  = r ? (f ^ {{(W-1){f[0]}}, 1'b0}) : f;
    it.ovf   = ov;
    it.rnd   = r;
    @(negedge clk);
    in_code = c; in_ovr = ov; mode = m; rand_en = r; in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        q.push_back(it);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 data", {18'd0, out_data}, 32'd0);
    check("R1 ovf", {31'd0, out_ovf}, 32'd0);
    check("R1 clk_p", {31'd0, out_clk_p}, 32'd0);
    check("R1 clk_n", {31'd0, out_clk_n}, 32'd1);
    rst_n = 1'b1;

    // R6: stabilizer status per mode
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      #1;
      check("R6 dcs_en", {31'd0, dcs_en}, {31'd0, (m == 1 || m == 2)});
    end

    // R2: ready relation with an empty register
    @(negedge clk); #1;
    check("R2 in_ready idle", {31'd0, in_ready}, 32'd1);

    // R4, R5, R8: formats without scrambling
    send(14'h0000, 1'b0, 2'd0, 1'b0);
    send(14'h3FFF, 1'b1, 2'd1, 1'b0);
    send(14'h2000, 1'b0, 2'd2, 1'b0);
    send(14'h1FFF, 1'b1, 2'd3, 1'b0);
    // R7: scrambling, bit0 both ways, both formats
    send(14'h1235, 1'b0, 2'd0, 1'b1);
    send(14'h1234, 1'b0, 2'd1, 1'b1);
    send(14'h2AAB, 1'b1, 2'd2, 1'b1);
    send(14'h0001, 1'b0, 2'd3, 1'b1);
    drain();

    // R2/R3 under back-pressure: mixed stream
    bp = 1'b1;
    for (int i = 0; i < 300; i++) begin
      send(14'((i * 2731 + 77) & 16'h3FFF), 1'(i % 5 == 0), 2'(i % 4), 1'((i / 3) % 2));
    end
    bp = 1'b0;
    drain();

    check("R3 all samples out", popped, 32'd308);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule